// File: doc/BRIEF.md
# Split Private/Shared Coherence Directory Slice

This block is the directory controller for one tile's slice of a sparse coherence directory. It keeps two set-associative tag arrays that share one set count. The private array is large and 6-way by default. Each of its entries holds only a tag and the ID of the single core caching the block. The shared array is small and 2-way. Each of its entries holds a tag, an owner ID and a full sharer bit vector. A block starts in the private array when it is first fetched. It moves to the shared array when a second core touches it, and it never moves back.

Each request carries an operation, a core ID and a block address. The shared array is always probed first. The private array is probed only on a shared miss, and its result arrives a configurable number of cycles later. The controller reports the following:
- hit or miss, and which array supplied the entry;
- whether the parallel L2 access can be cancelled;
- whether a read is forwarded to the owner;
- which cores must drop their copy on a write.

A victim evicted from either array leaves the directory. Its eviction message carries the victim address and a bit mask of the cores that must invalidate. The controller handles one request at a time.

Top module: `dir_ctrl`

## Requirements
- R1: After reset both arrays are empty, `req_ready_o` is 1, and `rsp_valid_o` and `evict_valid_o` are 0.
- R2: A request is accepted on a rising edge where `req_valid_i` and `req_ready_o` are both 1. The address index is its low log2(SETS) bits and the tag is the rest. A shared-array hit is reported with `rsp_valid_o` high in the cycle after the next rising edge. Otherwise the response comes PV_LAT edges later. `req_ready_o` is 0 from acceptance until the response cycle, and it is 1 in the response cycle.
- R3: Operation codes are 0 read, 1 write and 2 write-back. Source codes are 0 none, 1 shared and 2 private. A read or write that misses both arrays reports hit 0 and source 0, with no forward, cancel or invalidation. It allocates a private entry with the requester as owner. A later read or write by that owner hits with source 2 and changes nothing else.
- R4: A read that hits a private entry owned by another core reports source 2 and forwards to the old owner. It moves the entry to the shared array with owner unchanged and sharers {old owner, requester}, and it removes the private entry.
- R5: A write that hits a private entry owned by another core reports source 2 and invalidates the old owner. It cancels L2 and moves the entry to the shared array with owner and sole sharer set to the requester.
- R6: A read that hits the shared array adds the requester to the sharer vector. It forwards to the owner unless the requester is the owner, and it does not cancel L2.
- R7: A write that hits the shared array invalidates every sharer except the requester and cancels L2. It makes the requester the owner and sole sharer, and the entry stays in the shared array.
- R8: A write-back by the owner of a private entry reports hit with source 2 and removes the entry. A write-back by a non-owner to a private entry changes nothing.
- R9: A write-back to a shared entry clears the requester's sharer bit. When no sharer remains, the entry is removed and is not placed in the private array, so the next access to it misses.
- R10: A miss allocation into a full private set evicts the least recently used way. It sends `evict_valid_o` with the victim address and the one-hot mask of its owner, in the same cycle as the response.
- R11: A migration into a full shared set evicts the least recently used shared way. It sends `evict_valid_o` with the victim address and the victim's sharer vector as the target mask.
- R12: A write-back that misses both arrays reports a miss and allocates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, can accept |
| req_op_i | input | 2 | 0 read, 1 write, 2 write-back |
| req_core_i | input | CORE_W | Requesting core ID |
| req_addr_i | input | ADDR_W | Block address (index in low bits) |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_hit_o | output | 1 | Directory hit |
| rsp_src_o | output | 2 | 0 none, 1 shared array, 2 private array |
| rsp_fwd_o | output | 1 | Forward the read to the owner |
| rsp_fwd_core_o | output | CORE_W | Core the read is forwarded to |
| rsp_cancel_l2_o | output | 1 | Cancel the parallel L2 access |
| rsp_inv_o | output | NUM_CORES | Cores to invalidate for this write |
| evict_valid_o | output | 1 | Eviction message valid |
| evict_addr_o | output | ADDR_W | Address of the evicted block |
| evict_tgt_o | output | NUM_CORES | Cores that must drop the evicted block |

## Verification
A directed pass walks one block through its whole life:
- miss;
- owner re-access;
- read migration;
- shared read and write;
- partial and final write-back.

The pass then repeats the pattern with a write migration, a non-owner write-back and a write-back to an absent block. These separate the private and shared paths by response latency and source code, and they show that an entry never comes back into the private array.

Filling one private set with six owners is followed by a touch that reorders recency. Filling the shared set through two migrations is followed by a third. Both separate true LRU from a fixed victim choice and check the eviction masks.

A long pseudo-random run over a small address space then mixes all three operations from all cores. It exercises repeated eviction and migration against a behavioural model.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_WB    = 2'd2
  } dir_op_e;

  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_SHARED  = 2'd1,
    SRC_PRIVATE = 2'd2
  } dir_src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SH   = 2'd1,
    ST_PV   = 2'd2
  } dir_state_e;
endpackage

// File: rtl/dir_lru.sv
// Per-set recency ages: 0 = most recent, WAYS-1 = least recent.
module dir_lru #(
  parameter int WAYS = 2,
  parameter int WW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][WW-1:0] age_i,
  input  logic [WAYS-1:0]         valid_i,
  input  logic [WW-1:0]           touch_i,
  output logic [WAYS-1:0][WW-1:0] age_o,
  output logic [WW-1:0]           victim_o
);
  logic [WW-1:0] touch_age;

  always_comb begin
    touch_age = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (WW'(w) == touch_i) touch_age = age_i[w];
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_age
    always_comb begin
      if (WW'(w) == touch_i)          age_o[w] = '0;
      else if (age_i[w] < touch_age)  age_o[w] = age_i[w] + WW'(1);
      else                            age_o[w] = age_i[w];
    end
  end

  // first free way wins, else the oldest
  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !valid_i[w]) begin
        victim_o = WW'(w);
        found    = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_i[w] == WW'(WAYS - 1)) victim_o = WW'(w);
      end
    end
  end
endmodule

// File: rtl/dir_array.sv
module dir_array #(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 2,
  parameter int IW     = $clog2(SETS),
  parameter int WW     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IW-1:0]     idx_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              hit_o,
  output logic [WW-1:0]     hit_way_o,
  output logic [DATA_W-1:0] hit_data_o,
  output logic [WW-1:0]     vic_way_o,
  output logic              vic_valid_o,
  output logic [TAG_W-1:0]  vic_tag_o,
  output logic [DATA_W-1:0] vic_data_o,
  input  logic              wr_en_i,
  input  logic              inv_en_i,
  input  logic              touch_en_i,
  input  logic [WW-1:0]     way_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [WAYS-1:0]           valid_q [SETS];
  logic [WAYS-1:0][WW-1:0]   age_q   [SETS];
  logic [TAG_W-1:0]          tag_q   [SETS][WAYS];
  logic [DATA_W-1:0]         data_q  [SETS][WAYS];
  logic [WAYS-1:0]           match;
  logic [WAYS-1:0][WW-1:0]   age_nxt;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = valid_q[idx_i][w] && (tag_q[idx_i][w] == tag_i);
  end

  always_comb begin
    hit_way_o  = '0;
    hit_data_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit_way_o  = WW'(w);
        hit_data_o = data_q[idx_i][w];
      end
    end
  end

  assign hit_o = |match;

  dir_lru #(.WAYS(WAYS), .WW(WW)) u_lru (
    .age_i    (age_q[idx_i]),
    .valid_i  (valid_q[idx_i]),
    .touch_i  (way_i),
    .age_o    (age_nxt),
    .victim_o (vic_way_o)
  );

  assign vic_valid_o = valid_q[idx_i][vic_way_o];
  assign vic_tag_o   = tag_q[idx_i][vic_way_o];
  assign vic_data_o  = data_q[idx_i][vic_way_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WW'(w);
      end
    end else begin
      if (wr_en_i)       valid_q[idx_i][way_i] <= 1'b1;
      else if (inv_en_i) valid_q[idx_i][way_i] <= 1'b0;
      if (wr_en_i || touch_en_i) age_q[idx_i] <= age_nxt;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[idx_i][way_i]  <= tag_i;
      data_q[idx_i][way_i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int SETS      = 4,
  parameter int SH_WAYS   = 2,
  parameter int PV_WAYS   = 6,
  parameter int PV_LAT    = 2,
  parameter int CORE_W    = $clog2(NUM_CORES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [1:0]           req_op_i,
  input  logic [CORE_W-1:0]    req_core_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  output logic                 rsp_valid_o,
  output logic                 rsp_hit_o,
  output logic [1:0]           rsp_src_o,
  output logic                 rsp_fwd_o,
  output logic [CORE_W-1:0]    rsp_fwd_core_o,
  output logic                 rsp_cancel_l2_o,
  output logic [NUM_CORES-1:0] rsp_inv_o,
  output logic                 evict_valid_o,
  output logic [ADDR_W-1:0]    evict_addr_o,
  output logic [NUM_CORES-1:0] evict_tgt_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int SH_DW = NUM_CORES + CORE_W;
  localparam int PV_DW = CORE_W;
  localparam int SH_WW = (SH_WAYS > 1) ? $clog2(SH_WAYS) : 1;
  localparam int PV_WW = (PV_WAYS > 1) ? $clog2(PV_WAYS) : 1;
  localparam int CNT_W = $clog2(PV_LAT + 1);

  dir_state_e          state_q;
  dir_op_e             op_q;
  logic [CORE_W-1:0]   core_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [CNT_W-1:0]    cnt_q;

  logic [IDX_W-1:0]    idx;
  logic [TAG_W-1:0]    tag;
  logic [NUM_CORES-1:0] req_bit;

  // shared array port signals
  logic                sh_hit, sh_vic_valid;
  logic [SH_WW-1:0]    sh_hit_way, sh_vic_way, sh_way;
  logic [SH_DW-1:0]    sh_hit_data, sh_vic_data, sh_wdata;
  logic [TAG_W-1:0]    sh_vic_tag;
  logic                sh_wr, sh_inv;
  logic [CORE_W-1:0]   sh_own;
  logic [NUM_CORES-1:0] sh_shr, sh_shr_wb;

  // private array port signals
  logic                pv_hit, pv_vic_valid;
  logic [PV_WW-1:0]    pv_hit_way, pv_vic_way, pv_way;
  logic [PV_DW-1:0]    pv_hit_data, pv_vic_data, pv_wdata;
  logic [TAG_W-1:0]    pv_vic_tag;
  logic                pv_wr, pv_inv, pv_touch;

  logic                sh_decide, pv_decide, decide;
  logic                n_hit, n_fwd, n_cancel, n_ev;
  logic [1:0]          n_src;
  logic [CORE_W-1:0]   n_fcore;
  logic [NUM_CORES-1:0] n_inv, n_et;
  logic [ADDR_W-1:0]   n_ea;

  assign idx     = addr_q[IDX_W-1:0];
  assign tag     = addr_q[ADDR_W-1:IDX_W];
  assign req_bit = NUM_CORES'(1) << core_q;
  assign sh_own  = sh_hit_data[CORE_W-1:0];
  assign sh_shr  = sh_hit_data[SH_DW-1:CORE_W];
  assign sh_shr_wb = sh_shr & ~req_bit;

  dir_array #(.SETS(SETS), .WAYS(SH_WAYS), .TAG_W(TAG_W), .DATA_W(SH_DW)) u_sh (
    .clk_i, .rst_ni,
    .idx_i(idx), .tag_i(tag),
    .hit_o(sh_hit), .hit_way_o(sh_hit_way), .hit_data_o(sh_hit_data),
    .vic_way_o(sh_vic_way), .vic_valid_o(sh_vic_valid),
    .vic_tag_o(sh_vic_tag), .vic_data_o(sh_vic_data),
    .wr_en_i(sh_wr), .inv_en_i(sh_inv), .touch_en_i(1'b0),
    .way_i(sh_way), .wr_data_i(sh_wdata)
  );

  dir_array #(.SETS(SETS), .WAYS(PV_WAYS), .TAG_W(TAG_W), .DATA_W(PV_DW)) u_pv (
    .clk_i, .rst_ni,
    .idx_i(idx), .tag_i(tag),
    .hit_o(pv_hit), .hit_way_o(pv_hit_way), .hit_data_o(pv_hit_data),
    .vic_way_o(pv_vic_way), .vic_valid_o(pv_vic_valid),
    .vic_tag_o(pv_vic_tag), .vic_data_o(pv_vic_data),
    .wr_en_i(pv_wr), .inv_en_i(pv_inv), .touch_en_i(pv_touch),
    .way_i(pv_way), .wr_data_i(pv_wdata)
  );

  assign sh_decide = (state_q == ST_SH) && sh_hit;
  assign pv_decide = (state_q == ST_PV) && (cnt_q == '0);
  assign decide    = sh_decide || pv_decide;

  always_comb begin
    n_hit = 1'b0; n_src = SRC_NONE; n_fwd = 1'b0; n_fcore = '0;
    n_cancel = 1'b0; n_inv = '0; n_ev = 1'b0; n_ea = '0; n_et = '0;
    sh_wr = 1'b0; sh_inv = 1'b0; sh_way = sh_hit_way; sh_wdata = '0;
    pv_wr = 1'b0; pv_inv = 1'b0; pv_touch = 1'b0; pv_way = pv_hit_way; pv_wdata = core_q;
    if (sh_decide) begin
      n_hit = 1'b1;
      n_src = SRC_SHARED;
      if (op_q == OP_WB) begin
        if ((sh_shr & req_bit) != '0) begin
          if (sh_shr_wb == '0) sh_inv = 1'b1;
          else begin
            sh_wr    = 1'b1;
            sh_wdata = {sh_shr_wb, sh_own};
          end
        end
      end else if (op_q == OP_WRITE) begin
        n_inv    = sh_shr & ~req_bit;
        n_cancel = 1'b1;
        sh_wr    = 1'b1;
        sh_wdata = {req_bit, core_q};
      end else begin
        sh_wr    = 1'b1;
        sh_wdata = {sh_shr | req_bit, sh_own};
        if (sh_own != core_q) begin
          n_fwd   = 1'b1;
          n_fcore = sh_own;
        end
      end
    end else if (pv_decide) begin
      if (pv_hit) begin
        n_hit = 1'b1;
        n_src = SRC_PRIVATE;
        if (pv_hit_data == core_q) begin
          if (op_q == OP_WB) pv_inv = 1'b1;
          else               pv_touch = 1'b1;
        end else if (op_q != OP_WB) begin
          // migrate into shared array, private copy dropped
          pv_inv = 1'b1;
          sh_wr  = 1'b1;
          sh_way = sh_vic_way;
          if (sh_vic_valid) begin
            n_ev = 1'b1;
            n_ea = {sh_vic_tag, idx};
            n_et = sh_vic_data[SH_DW-1:CORE_W];
          end
          if (op_q == OP_WRITE) begin
            sh_wdata = {req_bit, core_q};
            n_inv    = NUM_CORES'(1) << pv_hit_data;
            n_cancel = 1'b1;
          end else begin
            sh_wdata = {req_bit | (NUM_CORES'(1) << pv_hit_data), pv_hit_data};
            n_fwd    = 1'b1;
            n_fcore  = pv_hit_data;
          end
        end
      end else if (op_q != OP_WB) begin
        pv_wr  = 1'b1;
        pv_way = pv_vic_way;
        if (pv_vic_valid) begin
          n_ev = 1'b1;
          n_ea = {pv_vic_tag, idx};
          n_et = NUM_CORES'(1) << pv_vic_data;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_READ;
      core_q  <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          op_q    <= dir_op_e'(req_op_i);
          core_q  <= req_core_i;
          addr_q  <= req_addr_i;
          state_q <= ST_SH;
        end
        ST_SH: begin
          if (sh_hit) state_q <= ST_IDLE;
          else begin
            state_q <= ST_PV;
            cnt_q   <= CNT_W'(PV_LAT - 1);
          end
        end
        ST_PV: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - CNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0; rsp_hit_o <= 1'b0; rsp_src_o <= '0;
      rsp_fwd_o <= 1'b0; rsp_fwd_core_o <= '0; rsp_cancel_l2_o <= 1'b0;
      rsp_inv_o <= '0; evict_valid_o <= 1'b0; evict_addr_o <= '0; evict_tgt_o <= '0;
    end else begin
      rsp_valid_o     <= decide;
      rsp_hit_o       <= decide & n_hit;
      rsp_src_o       <= decide ? n_src : 2'd0;
      rsp_fwd_o       <= decide & n_fwd;
      rsp_fwd_core_o  <= decide ? n_fcore : '0;
      rsp_cancel_l2_o <= decide & n_cancel;
      rsp_inv_o       <= decide ? n_inv : '0;
      evict_valid_o   <= decide & n_ev;
      evict_addr_o    <= decide ? n_ea : '0;
      evict_tgt_o     <= decide ? n_et : '0;
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
endmodule

// File: rtl/dir_ctrl_chk.sv
module dir_ctrl_chk #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int CORE_W    = $clog2(NUM_CORES)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic                 req_ready_o,
  input logic                 rsp_valid_o,
  input logic                 rsp_hit_o,
  input logic [1:0]           rsp_src_o,
  input logic                 rsp_fwd_o,
  input logic [CORE_W-1:0]    rsp_fwd_core_o,
  input logic                 rsp_cancel_l2_o,
  input logic [NUM_CORES-1:0] rsp_inv_o,
  input logic                 evict_valid_o,
  input logic [ADDR_W-1:0]    evict_addr_o,
  input logic [NUM_CORES-1:0] evict_tgt_o
);
  // R2
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (!req_ready_o && !rsp_valid_o));

  // R2
  rsp_with_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o);

  // R3
  miss_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |->
      (rsp_src_o == 2'd0 && !rsp_fwd_o && !rsp_cancel_l2_o && rsp_inv_o == '0));

  // R6
  fwd_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fwd_o |-> (rsp_valid_o && rsp_hit_o && !rsp_cancel_l2_o));

  // R7
  cancel_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_cancel_l2_o |-> (rsp_valid_o && rsp_hit_o && !rsp_fwd_o));

  // R10
  evict_with_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o |-> rsp_valid_o);

  // R11
  evict_has_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o |-> (evict_tgt_o != '0));

  // R1
  idle_outputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!evict_valid_o && evict_addr_o == '0 && rsp_fwd_core_o == '0));
endmodule

bind dir_ctrl dir_ctrl_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .CORE_W(CORE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_src_o(rsp_src_o),
  .rsp_fwd_o(rsp_fwd_o), .rsp_fwd_core_o(rsp_fwd_core_o), .rsp_cancel_l2_o(rsp_cancel_l2_o),
  .rsp_inv_o(rsp_inv_o), .evict_valid_o(evict_valid_o), .evict_addr_o(evict_addr_o),
  .evict_tgt_o(evict_tgt_o)
);

// File: tb/dir_ctrl_test.sv
module dir_ctrl_test;
  localparam int NC = 4, AW = 8, SETS = 4, SHW = 2, PVW = 6, PVL = 2;
  localparam int IW = 2, CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4ns clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [CW-1:0] req_core = '0;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid, rsp_hit, rsp_fwd, rsp_cancel, ev_valid;
  logic [1:0]    rsp_src;
  logic [CW-1:0] rsp_fcore;
  logic [NC-1:0] rsp_inv, ev_tgt;
  logic [AW-1:0] ev_addr;

  dir_ctrl #(.NUM_CORES(NC), .ADDR_W(AW), .SETS(SETS), .SH_WAYS(SHW),
             .PV_WAYS(PVW), .PV_LAT(PVL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_core_i(req_core), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_src_o(rsp_src),
    .rsp_fwd_o(rsp_fwd), .rsp_fwd_core_o(rsp_fcore), .rsp_cancel_l2_o(rsp_cancel),
    .rsp_inv_o(rsp_inv), .evict_valid_o(ev_valid), .evict_addr_o(ev_addr),
    .evict_tgt_o(ev_tgt)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural model: flat tables with timestamps for recency
  bit sv [SETS][SHW]; int stg [SETS][SHW]; int sow [SETS][SHW]; int ssh [SETS][SHW]; int sts [SETS][SHW];
  bit pv [SETS][PVW]; int ptg [SETS][PVW]; int pow [SETS][PVW]; int pts [SETS][PVW];
  int tick = 0;

  bit e_ready, e_rv, e_hit, e_fwd, e_can, e_ev;
  int e_src, e_fc, e_inv, e_ea, e_et, mcnt;
  string e_tag;
  bit p_hit, p_fwd, p_can, p_ev, p_sh;
  int p_src, p_fc, p_inv, p_ea, p_et;
  string p_tag;

  task automatic model_reset();
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < SHW; w++) sv[s][w] = 0;
      for (int w = 0; w < PVW; w++) pv[s][w] = 0;
    end
    e_ready = 1; e_rv = 0; e_hit = 0; e_fwd = 0; e_can = 0; e_ev = 0;
    e_src = 0; e_fc = 0; e_inv = 0; e_ea = 0; e_et = 0; mcnt = 0; e_tag = "R1";
  endtask

  function automatic int sh_victim(int s);
    int v = -1, best = 0;
    for (int w = 0; w < SHW; w++) if (v < 0 && !sv[s][w]) v = w;
    if (v >= 0) return v;
    best = sts[s][0]; v = 0;
    for (int w = 1; w < SHW; w++) if (sts[s][w] < best) begin best = sts[s][w]; v = w; end
    return v;
  endfunction

  function automatic int pv_victim(int s);
    int v = -1, best = 0;
    for (int w = 0; w < PVW; w++) if (v < 0 && !pv[s][w]) v = w;
    if (v >= 0) return v;
    best = pts[s][0]; v = 0;
    for (int w = 1; w < PVW; w++) if (pts[s][w] < best) begin best = pts[s][w]; v = w; end
    return v;
  endfunction

  task automatic model_decide(int op, int c, int addr);
    int s = addr % SETS, tg = addr / SETS, rb = 1 << c, sw = -1, pw = -1, v, old;
    p_hit = 0; p_fwd = 0; p_can = 0; p_ev = 0; p_sh = 0;
    p_src = 0; p_fc = 0; p_inv = 0; p_ea = 0; p_et = 0; p_tag = "R3";
    for (int w = 0; w < SHW; w++) if (sv[s][w] && stg[s][w] == tg) sw = w;
    for (int w = 0; w < PVW; w++) if (pv[s][w] && ptg[s][w] == tg) pw = w;
    if (sw >= 0) begin
      p_sh = 1; p_hit = 1; p_src = 1;
      if (op == 0) begin
        p_tag = "R6"; ssh[s][sw] |= rb;
        if (sow[s][sw] != c) begin p_fwd = 1; p_fc = sow[s][sw]; end
        sts[s][sw] = ++tick;
      end else if (op == 1) begin
        p_tag = "R7"; p_inv = ssh[s][sw] & ~rb; p_can = 1;
        sow[s][sw] = c; ssh[s][sw] = rb; sts[s][sw] = ++tick;
      end else begin
        p_tag = "R9";
        if ((ssh[s][sw] & rb) != 0) begin
          ssh[s][sw] &= ~rb;
          if (ssh[s][sw] == 0) sv[s][sw] = 0; else sts[s][sw] = ++tick;
        end
      end
    end else if (pw >= 0) begin
      p_hit = 1; p_src = 2; old = pow[s][pw];
      if (old == c) begin
        if (op == 2) begin p_tag = "R8"; pv[s][pw] = 0; end
        else begin p_tag = "R3"; pts[s][pw] = ++tick; end
      end else if (op == 2) begin
        p_tag = "R8";
      end else begin
        pv[s][pw] = 0;
        v = sh_victim(s);
        p_tag = (op == 1) ? "R5" : "R4";
        if (sv[s][v]) begin
          p_ev = 1; p_ea = stg[s][v] * SETS + s; p_et = ssh[s][v]; p_tag = "R11";
        end
        sv[s][v] = 1; stg[s][v] = tg; sts[s][v] = ++tick;
        if (op == 1) begin
          sow[s][v] = c; ssh[s][v] = rb; p_inv = 1 << old; p_can = 1;
        end else begin
          sow[s][v] = old; ssh[s][v] = rb | (1 << old); p_fwd = 1; p_fc = old;
        end
      end
    end else if (op == 2) begin
      p_tag = "R12";
    end else begin
      v = pv_victim(s);
      if (pv[s][v]) begin
        p_ev = 1; p_ea = ptg[s][v] * SETS + s; p_et = 1 << pow[s][v]; p_tag = "R10";
      end
      pv[s][v] = 1; ptg[s][v] = tg; pow[s][v] = c; pts[s][v] = ++tick;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      e_rv = 0; e_hit = 0; e_fwd = 0; e_can = 0; e_ev = 0;
      e_src = 0; e_fc = 0; e_inv = 0; e_ea = 0; e_et = 0; e_tag = "R2";
      if (e_ready && req_valid) begin
        model_decide(int'(req_op), int'(req_core), int'(req_addr));
        e_ready = 0;
        mcnt = p_sh ? 1 : 1 + PVL;
      end else if (!e_ready) begin
        mcnt--;
        if (mcnt == 0) begin
          e_ready = 1; e_rv = 1; e_hit = p_hit; e_src = p_src; e_fwd = p_fwd; e_fc = p_fc;
          e_can = p_can; e_inv = p_inv; e_ev = p_ev; e_ea = p_ea; e_et = p_et; e_tag = p_tag;
        end
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "ready", int'(req_ready), int'(e_ready));
      chk("R2", "rsp_valid", int'(rsp_valid), int'(e_rv));
      if (e_rv) begin
        chk(e_tag, "hit", int'(rsp_hit), int'(e_hit));
        chk(e_tag, "src", int'(rsp_src), e_src);
        chk(e_tag, "fwd", int'(rsp_fwd), int'(e_fwd));
        if (e_fwd) chk(e_tag, "fwd_core", int'(rsp_fcore), e_fc);
        chk(e_tag, "cancel_l2", int'(rsp_cancel), int'(e_can));
        chk(e_tag, "inv", int'(rsp_inv), e_inv);
        chk(e_tag, "evict_valid", int'(ev_valid), int'(e_ev));
        if (e_ev) begin
          chk(e_tag, "evict_addr", int'(ev_addr), e_ea);
          chk(e_tag, "evict_tgt", int'(ev_tgt), e_et);
        end
      end else begin
        chk("R2", "evict_valid idle", int'(ev_valid), 0);
      end
    end
  end

  task automatic send(int op, int c, int tg, int s);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = 2'(op); req_core = CW'(c); req_addr = AW'(tg * SETS + s); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", int'(req_ready), 1);
    chk("R1", "rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", int'(req_ready), 1);
    chk("R1", "evict_valid after reset", int'(ev_valid), 0);

    // one block through its whole life, set 0
    send(0, 0, 1, 0);  // R3 miss
    send(0, 0, 1, 0);  // R3 owner hit
    send(0, 1, 1, 0);  // R4 read migration
    send(0, 2, 1, 0);  // R6 shared read
    send(1, 2, 1, 0);  // R7 shared write
    send(2, 2, 1, 0);  // R9 last sharer leaves
    send(0, 3, 1, 0);  // R9 back as a miss
    // write migration, set 1
    send(0, 1, 2, 1);
    send(1, 0, 2, 1);  // R5
    // write-back cases, set 2
    send(0, 2, 3, 2);
    send(2, 1, 3, 2);  // R8 non-owner ignored
    send(2, 2, 3, 2);  // R8 owner removes
    send(0, 3, 3, 2);  // R8 now a miss
    send(2, 0, 9, 2);  // R12 absent block
    send(0, 0, 9, 2);  // R12 still a miss
    // private LRU, set 3
    for (int t = 10; t < 16; t++) send(0, t % NC, t, 3);
    send(0, 10 % NC, 10, 3);
    send(0, 1, 16, 3);  // R10 evicts tag 11
    send(0, 0, 17, 3);  // R10 evicts tag 12
    // shared LRU, set 1 already holds tag 2
    send(0, 0, 20, 1);
    send(0, 1, 20, 1);
    send(0, 2, 21, 1);
    send(0, 3, 21, 1);  // R11 evicts tag 2
    // mixed traffic
    for (int i = 0; i < 2000; i++)
      send($urandom_range(0, 2), $urandom_range(0, NC - 1), $urandom_range(0, 9), $urandom_range(0, SETS - 1));
    repeat (8) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule